// File: doc/BRIEF.md
# SMBus Block-Write Configuration Receiver

This block is a receive-only serial slave for a two-wire bus. It takes SMBus block-write transactions and turns them into byte writes to a small on-chip register file. The SCL and SDA pins arrive as raw inputs. A chain of flops brings them into the system clock domain, and edge detectors then find START, repeated START, STOP and the data-bit edges. The slave answers one fixed 7-bit address and only in the write direction. It acknowledges by asserting an open-drain pull-down enable. It never touches SCL.

After the address, the host sends a command byte and then a byte-count byte. The slave acknowledges both and writes neither. Every data byte after them goes to the next register index, starting at zero. Each stored byte also appears for one cycle on a write stream made of `wr_valid`, `wr_index` and `wr_data`. This stream has no ready signal and no back-pressure: the sink must take a byte in the cycle that `wr_valid` is high. The register file inside the block is such a sink, and its contents appear on `regs_q`. The `xfer_ok` level reports that the current transaction has a legal byte count.

Top module: `smb_blkwr_rx`

## Requirements
- R1: After reset, `regs_q` is all zero and `sda_oe`, `xfer_ok` and `wr_valid` are low.
- R2: When the first byte after a START is address 7'b1101001 with R/W = 0 (byte value 8'hD2, sent MSB first), the slave acknowledges it by holding `sda_oe` high through the ninth SCL high phase.
- R3: When the address differs from 7'b1101001, or R/W = 1, the address byte gets no acknowledge. Every later byte up to the next START is also ignored: no acknowledge, no write and no change to `xfer_ok`.
- R4: The command byte and the byte-count byte of an addressed transaction are acknowledged and are never written. `xfer_ok` rises when the acknowledge of a byte-count byte in the range 1..MAX_COUNT begins. It stays high until the next START, which clears it.
- R5: Data bytes are shifted MSB first. They are written in arrival order to indices 0, 1, 2 and so on. Each write is a single-cycle `wr_valid` pulse carrying `wr_index` and `wr_data`. Register i appears on `regs_q[8*i+7:8*i]`.
- R6: A data byte whose index is at or beyond NUM_REGS, or at or beyond the byte count, is acknowledged but produces no write. `regs_q` does not change in any cycle without a write.
- R7: When the byte count is 0 or greater than MAX_COUNT, every byte is still acknowledged, but `xfer_ok` stays low and no data byte is written.
- R8: A STOP or a repeated START before the eighth bit of a byte completes drops that byte without a write. Bytes already acknowledged stay in the registers.
- R9: `sda_oe` is asserted only after the SCL falling edge that ends the eighth bit of an acknowledged byte. It is released after the next SCL falling edge, so it never changes while SCL is high.
- R10: After a repeated START the slave matches the address again, and a complete new transaction is accepted without an intervening STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level (wired bus value) |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| wr_valid | output | 1 | One-cycle write strobe, no back-pressure |
| wr_index | output | IDXW | Register index of the write |
| wr_data | output | 8 | Byte written |
| xfer_ok | output | 1 | Current transaction has a legal byte count |
| regs_q | output | 8*NUM_REGS | Register file contents, register 0 in the low byte |

## Verification
The bench builds the block with its default values: NUM_REGS = 3, MAX_COUNT = 32, address 7'b1101001 and a two-stage synchronizer. With only three registers, a short transaction can run past the end of the register file, so the dropping of surplus bytes is exercised alongside the byte-count limits. A count of 40 tests the upper bound of the legal range, and a count of 0 tests the lower bound. A bus model that drives sixteen system clocks per SCL phase covers both a STOP and a repeated START arriving in the middle of a byte.

// File: rtl/smb_blkwr_pkg.sv
package smb_blkwr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_IGNORE
  } rx_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_DATA
  } byte_phase_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic line_rise,
  output logic line_fall
);

  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], line_i};
  end

  assign line_s    = pipe[STAGES-1];
  assign line_rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign line_fall = ~pipe[STAGES-1] & pipe[STAGES];

endmodule

// File: rtl/smb_rx_fsm.sv
module smb_rx_fsm
  import smb_blkwr_pkg::*;
#(
  parameter logic [6:0] ADDR7     = 7'h69,
  parameter int         NUM_REGS  = 3,
  parameter int         MAX_COUNT = 32,
  parameter int         IDXW      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_s,
  input  logic            sda_rise,
  input  logic            sda_fall,
  output logic            sda_oe,
  output logic            wr_valid,
  output logic [IDXW-1:0] wr_index,
  output logic [7:0]      wr_data,
  output logic            xfer_ok
);

  localparam logic [7:0] NREG_B = 8'(NUM_REGS);
  localparam logic [7:0] MAXC_B = 8'(MAX_COUNT);
  localparam logic [7:0] ADDR_W = {ADDR7, 1'b0};

  rx_state_e   state;
  byte_phase_e phase;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic [7:0]  count_q;
  logic [7:0]  didx;

  logic start_det, stop_det, byte_done, count_legal, data_keep;

  assign start_det   = sda_fall & scl_s;
  assign stop_det    = sda_rise & scl_s;
  assign byte_done   = scl_fall && (bitcnt == 4'd8);
  assign count_legal = (shreg != 8'd0) && (shreg <= MAXC_B);
  assign data_keep   = xfer_ok && (didx < count_q) && (didx < NREG_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      count_q  <= '0;
      didx     <= '0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_index <= '0;
      wr_data  <= '0;
      xfer_ok  <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (start_det) begin
        state   <= ST_RECV;
        phase   <= PH_ADDR;
        bitcnt  <= '0;
        didx    <= '0;
        sda_oe  <= 1'b0;
        xfer_ok <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RECV: begin
            if (scl_rise && (bitcnt < 4'd8)) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              case (phase)
                PH_ADDR: begin
                  if (shreg == ADDR_W) begin
                    sda_oe <= 1'b1;
                    state  <= ST_ACK;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                PH_CMD: begin
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
                PH_COUNT: begin
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                  count_q <= shreg;
                  if (count_legal) xfer_ok <= 1'b1;
                end
                default: begin
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                  if (data_keep) begin
                    wr_valid <= 1'b1;
                    wr_index <= didx[IDXW-1:0];
                    wr_data  <= shreg;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_RECV;
              bitcnt <= '0;
              case (phase)
                PH_ADDR:  phase <= PH_CMD;
                PH_CMD:   phase <= PH_COUNT;
                PH_COUNT: phase <= PH_DATA;
                default:  if (didx != 8'hFF) didx <= didx + 8'd1;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall)); // R9
  AST_RELEASE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R9
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (int'(wr_index) < NUM_REGS)); // R6
  AST_WR_NEEDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> xfer_ok); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && !xfer_ok)); // R4

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int NUM_REGS = 3,
  parameter int IDXW     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IDXW-1:0]       widx,
  input  logic [7:0]            wdata,
  output logic [NUM_REGS*8-1:0] regs_q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs_q[i*8 +: 8] <= 8'h00;
      else if (we && (widx == IDXW'(i)))   regs_q[i*8 +: 8] <= wdata;
    end
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> $stable(regs_q)); // R6

endmodule

// File: rtl/smb_blkwr_rx.sv
module smb_blkwr_rx #(
  parameter logic [6:0] ADDR7       = 7'h69,
  parameter int         NUM_REGS    = 3,
  parameter int         MAX_COUNT   = 32,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDXW        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic                  wr_valid,
  output logic [IDXW-1:0]       wr_index,
  output logic [7:0]            wr_data,
  output logic                  xfer_ok,
  output logic [NUM_REGS*8-1:0] regs_q
);

  // line 0 = SCL, line 1 = SDA
  logic [1:0] pin_raw, pin_s, pin_rise, pin_fall;
  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (pin_raw[g]),
      .line_s    (pin_s[g]),
      .line_rise (pin_rise[g]),
      .line_fall (pin_fall[g])
    );
  end

  smb_rx_fsm #(
    .ADDR7     (ADDR7),
    .NUM_REGS  (NUM_REGS),
    .MAX_COUNT (MAX_COUNT),
    .IDXW      (IDXW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (pin_s[0]),
    .scl_rise (pin_rise[0]),
    .scl_fall (pin_fall[0]),
    .sda_s    (pin_s[1]),
    .sda_rise (pin_rise[1]),
    .sda_fall (pin_fall[1]),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_index (wr_index),
    .wr_data  (wr_data),
    .xfer_ok  (xfer_ok)
  );

  smb_regfile #(
    .NUM_REGS (NUM_REGS),
    .IDXW     (IDXW)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_valid),
    .widx   (wr_index),
    .wdata  (wr_data),
    .regs_q (regs_q)
  );

endmodule

// File: tb/tb_smb_blkwr_rx.sv
module tb_smb_blkwr_rx;

  localparam int NREG = 3;
  localparam int IW   = 2;
  localparam int PH   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe, wr_valid, xfer_ok;
  logic [IW-1:0] wr_index;
  logic [7:0] wr_data;
  logic [NREG*8-1:0] regs_q;
  logic sda_bus;

  assign sda_bus = host_sda & ~sda_oe;

  always #2 clk = ~clk;

  smb_blkwr_rx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_index(wr_index),
    .wr_data(wr_data), .xfer_ok(xfer_ok), .regs_q(regs_q)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // write log captured from the stream
  int wcnt = 0;
  logic [7:0] log_dat [64];
  int         log_idx [64];
  int oe_viol = 0;
  logic prev_oe = 1'b0;

  always @(negedge clk) begin
    if (wr_valid) begin
      if (wcnt < 64) begin
        log_dat[wcnt] = wr_data;
        log_idx[wcnt] = int'(wr_index);
      end
      wcnt = wcnt + 1;
    end
    if ((sda_oe !== prev_oe) && scl) oe_viol = oe_viol + 1;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt();
    repeat (PH) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wt();
    scl = 1'b1; wt();
    host_sda = 1'b0; wt();
    scl = 1'b0; wt();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wt();
    scl = 1'b1; wt();
    host_sda = 1'b1; wt();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      host_sda = b[i]; wt();
      scl = 1'b1; wt();
      scl = 1'b0; wt();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    host_sda = 1'b1; wt();
    scl = 1'b1; repeat (PH/2) @(negedge clk);
    ack = ~sda_bus;
    repeat (PH/2) @(negedge clk);
    scl = 1'b0; wt();
  endtask

  // row: addr byte, byte count, data bytes sent, data seed
  localparam logic [31:0] ROWS [8] = '{
    {8'hD2, 8'd3,  8'd3, 8'hA0},
    {8'hD2, 8'd2,  8'd2, 8'h11},
    {8'hD3, 8'd3,  8'd3, 8'h55},
    {8'h52, 8'd3,  8'd3, 8'h77},
    {8'hD2, 8'd0,  8'd2, 8'h99},
    {8'hD2, 8'd40, 8'd3, 8'h33},
    {8'hD2, 8'd5,  8'd5, 8'hC0},
    {8'hD2, 8'd3,  8'd1, 8'hE0}
  };

  logic [7:0] exp_regs [NREG];

  task automatic cmp_regs(input string tag);
    for (int r = 0; r < NREG; r++)
      chk(regs_q[r*8 +: 8] == exp_regs[r], tag, int'(regs_q[r*8 +: 8]), int'(exp_regs[r]));
  endtask

  initial begin
    bit ack;
    for (int r = 0; r < NREG; r++) exp_regs[r] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(regs_q == '0, "R1 regs", int'(regs_q), 0);
    chk(!sda_oe && !xfer_ok && !wr_valid, "R1 outputs", int'({sda_oe, xfer_ok, wr_valid}), 0);

    foreach (ROWS[t]) begin
      logic [7:0] ab, cnt, nb, seed;
      bit addr_ok, legal;
      int nwr, w0;
      {ab, cnt, nb, seed} = ROWS[t];
      addr_ok = (ab == 8'hD2);
      legal   = (cnt != 0) && (cnt <= 8'd32);
      nwr = 0;
      if (addr_ok && legal) begin
        nwr = int'(nb);
        if (int'(cnt) < nwr) nwr = int'(cnt);
        if (NREG < nwr) nwr = NREG;
      end
      w0 = wcnt;
      bus_start();
      chk(!xfer_ok, "R4 start clears xfer_ok", int'(xfer_ok), 0);
      send_byte(ab, ack);
      chk(ack == addr_ok, "R2/R3/R9 address ack", int'(ack), int'(addr_ok));
      send_byte(8'h00, ack);
      chk(ack == addr_ok, "R4/R3 command ack", int'(ack), int'(addr_ok));
      send_byte(cnt, ack);
      chk(ack == addr_ok, "R4/R7 count ack", int'(ack), int'(addr_ok));
      chk(xfer_ok == (addr_ok && legal), "R4/R7 xfer_ok", int'(xfer_ok), int'(addr_ok && legal));
      for (int k = 0; k < int'(nb); k++) begin
        send_byte(seed + 8'(k * 17), ack);
        chk(ack == addr_ok, "R5/R6 data ack", int'(ack), int'(addr_ok));
      end
      bus_stop();
      wt();
      chk(wcnt - w0 == nwr, "R5/R6/R7/R3 write count", wcnt - w0, nwr);
      for (int k = 0; k < nwr; k++) begin
        if (w0 + k < 64) begin
          chk(log_idx[w0+k] == k, "R5 write index", log_idx[w0+k], k);
          chk(log_dat[w0+k] == seed + 8'(k * 17), "R5 write data",
              int'(log_dat[w0+k]), int'(seed + 8'(k * 17)));
        end
        exp_regs[k] = seed + 8'(k * 17);
      end
      cmp_regs("R5/R6 regs");
      chk(!sda_oe, "R9 released after stop", int'(sda_oe), 0);
    end

    // R8: STOP in the middle of a data byte
    begin
      int w0;
      w0 = wcnt;
      bus_start();
      send_byte(8'hD2, ack);
      send_byte(8'h00, ack);
      send_byte(8'd3, ack);
      send_byte(8'h5A, ack);
      send_bits(8'hF0, 4);
      bus_stop();
      wt();
      exp_regs[0] = 8'h5A;
      chk(wcnt - w0 == 1, "R8 stop abort write count", wcnt - w0, 1);
      cmp_regs("R8 stop abort regs");
      chk(xfer_ok, "R4 xfer_ok held after stop", int'(xfer_ok), 1);
    end

    // R8/R10: repeated START mid-byte, then a fresh transaction
    begin
      int w0;
      w0 = wcnt;
      bus_start();
      send_byte(8'hD2, ack);
      send_byte(8'h00, ack);
      send_byte(8'd2, ack);
      send_bits(8'hFF, 3);
      bus_start();
      chk(wcnt - w0 == 0, "R8 repeated start drops byte", wcnt - w0, 0);
      send_byte(8'hD2, ack);
      chk(ack, "R10 address matched after repeated start", int'(ack), 1);
      send_byte(8'h00, ack);
      send_byte(8'd1, ack);
      chk(xfer_ok, "R10 xfer_ok", int'(xfer_ok), 1);
      send_byte(8'h3C, ack);
      send_byte(8'h44, ack);
      bus_stop();
      wt();
      exp_regs[0] = 8'h3C;
      chk(wcnt - w0 == 1, "R10/R6 write count", wcnt - w0, 1);
      cmp_regs("R10 regs");
    end

    chk(oe_viol == 0, "R9 sda_oe changed while SCL high", oe_viol, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule